// File: doc/BRIEF.md
# Partition power-up sequencer

This block brings one power partition of a chip out of the off state by driving four per-partition controls in a fixed order. Those controls are peripheral reset, power switch request, peripheral clock enable and isolation clamp release. A one-cycle request pulse carries the index of the partition to wake. The sequencer holds that partition's peripheral in reset and asks for power, unless the partition already reports powered. It then waits for the power status, enables the clock, lets it settle, removes the clamps, lets the outputs settle, and finally lets the peripheral out of reset.

All waits are measured in pulses of a one-microsecond tick input, so the same netlist works at any system clock rate. One counter serves both the power-good timeout (25000 ticks by default, that is 25 ms) and the two settle windows (10 ticks by default). A missing power-good ends the sequence with an error flag. The partition is then left safe: reset held, clock off, clamps applied, power request withdrawn. Per-partition control levels persist between sequences, so partitions woken earlier stay up while another one is sequenced.

Top module: `pwrup_seq`

## Requirements
- R1: Out of reset `busy`, `done` and `err` are 0, every bit of `rst_assert` is 1, and every bit of `pwr_on_req`, `clk_en` and `clamp_rel` is 0.
- R2: A request accepted while idle raises `busy` and sets `rst_assert[p]` for the selected partition p (the binary value of `req_part`) in the first cycle after acceptance. This holds even if that partition had earlier been released from reset.
- R3: If `pwr_status[p]` is 1 in the cycle after acceptance, no power request is issued, and `clk_en[p]` rises one cycle later.
- R4: Otherwise `pwr_on_req[p]` rises together with the reset. `clk_en[p]` rises in the cycle after the first cycle in which `pwr_status[p]` is seen as 1.
- R5: While waiting for power, the sequencer counts tick pulses starting with the cycle after the power request rises. If TIMEOUT_TICKS ticks are counted with the status still low, then in the cycle after the last one `err` is 1 and `busy` is 0. In that same cycle `pwr_on_req[p]`, `clk_en[p]` and `clamp_rel[p]` are 0 and `rst_assert[p]` is 1. `done` does not pulse.
- R6: If power status is first seen in the same cycle as the final timeout tick, the sequence continues normally and no error is raised.
- R7: After the clock rises, ticks are counted starting with the following cycle. `clamp_rel[p]` rises in the cycle after the SETTLE_TICKS-th tick, and clamps are never released while the partition's clock is off.
- R8: A second settle window of SETTLE_TICKS ticks is counted from the cycle after the clamps are released. In the cycle after it ends, `rst_assert[p]` falls, `done` pulses high for exactly one cycle, and `busy` is low.
- R9: `err` stays 1 after a timeout until the next accepted request, and reads 0 in the cycle after that acceptance.
- R10: A request that arrives while `busy` is 1, or whose index is NUM_PART or more, is ignored. No partition's outputs change, `busy` stays as it was, and no extra `done` appears.
- R11: A sequence changes only the selected partition's four controls. All other partitions keep their levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse every microsecond, drives all delay counting |
| req | input | 1 | Power-up request pulse |
| req_part | input | IDX_W | Index of the partition to wake, valid with `req` |
| pwr_status | input | NUM_PART | Per-partition powered indication from the power switches |
| busy | output | 1 | High from the cycle after acceptance until the sequence ends |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Power-good timeout flag, held until the next accepted request |
| rst_assert | output | NUM_PART | Per-partition peripheral reset, 1 = held in reset |
| pwr_on_req | output | NUM_PART | Per-partition power switch request, 1 = power on |
| clk_en | output | NUM_PART | Per-partition peripheral clock enable |
| clamp_rel | output | NUM_PART | Per-partition isolation clamp release, 1 = clamps removed |

## Verification
The two functions that can collide are power-good detection and timeout expiry. Both are decided in the power-wait state, and the final timeout tick can land in the very cycle the status bit is first seen high. The bench computes the timeout edge from the tick divider and raises the status exactly on that edge, and then one edge later. It judges the first case by a normal clock-enable edge and a `done` pulse with `err` low. It judges the second by `err` in the cycle after the final tick, with no clock enable and no `done`.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RESET   = 3'd1,
      ST_PWAIT   = 3'd2,
      ST_CLKON   = 3'd3,
      ST_SETTLE1 = 3'd4,
      ST_UNCLAMP = 3'd5,
      ST_SETTLE2 = 3'd6,
      ST_RELEASE = 3'd7
   } seq_state_e;

   // One-cycle commands from the controller to the selected partition's bank
   typedef struct packed {
      logic hold_rst;
      logic free_rst;
      logic pwr_up;
      logic pwr_drop;
      logic clk_up;
      logic clk_drop;
      logic unclamp;
      logic reclamp;
   } part_cmd_t;

endpackage

// File: rtl/pwrup_status_sync.sv
module pwrup_status_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] synced
);

   generate
      if (STAGES == 0) begin : g_direct
         assign synced = raw;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
            end else begin
               pipe_q[0] <= raw;
               for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
            end
         end

         assign synced = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pwrup_tick_timer.sv
module pwrup_tick_timer #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clear) begin
         count_q <= '0;
      end else if (tick) begin
         count_q <= count_q + CNT_W'(1);
      end
   end

   // The limit-th tick since the last clear
   assign hit = tick && (count_q == (limit - CNT_W'(1)));

endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
   import pwrup_pkg::*;
#(
   parameter int NUM_PART      = 8,
   parameter int IDX_W         = 3,
   parameter int CNT_W         = 15,
   parameter int TIMEOUT_TICKS = 25000,
   parameter int SETTLE_TICKS  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [IDX_W-1:0] req_part,
   input  logic             status_cur,
   input  logic             tmr_hit,
   output logic [IDX_W-1:0] idx_q,
   output part_cmd_t        cmd,
   output logic             tmr_clear,
   output logic [CNT_W-1:0] tmr_limit,
   output logic             busy,
   output logic             done,
   output logic             err
);

   localparam logic [IDX_W:0] PART_LIMIT = (IDX_W+1)'(NUM_PART);

   seq_state_e state_q;
   logic       accept;
   logic       timed_out;

   assign accept    = (state_q == ST_IDLE) && req && ({1'b0, req_part} < PART_LIMIT);
   assign timed_out = (state_q == ST_PWAIT) && !status_cur && tmr_hit;
   assign busy      = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  idx_q   <= req_part;
                  err     <= 1'b0;
                  state_q <= ST_RESET;
               end
            end
            ST_RESET:   state_q <= status_cur ? ST_CLKON : ST_PWAIT;
            ST_PWAIT: begin
               if (status_cur) begin
                  state_q <= ST_CLKON;
               end else if (tmr_hit) begin
                  err     <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_CLKON:   state_q <= ST_SETTLE1;
            ST_SETTLE1: if (tmr_hit) state_q <= ST_UNCLAMP;
            ST_UNCLAMP: state_q <= ST_SETTLE2;
            ST_SETTLE2: if (tmr_hit) state_q <= ST_RELEASE;
            ST_RELEASE: begin
               done    <= 1'b1;
               state_q <= ST_IDLE;
            end
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd       = '0;
      tmr_clear = 1'b0;
      tmr_limit = CNT_W'(SETTLE_TICKS);
      unique case (state_q)
         ST_RESET: begin
            cmd.hold_rst = 1'b1;
            cmd.pwr_up   = !status_cur;
            tmr_clear    = 1'b1;
         end
         ST_PWAIT: begin
            tmr_limit = CNT_W'(TIMEOUT_TICKS);
            if (timed_out) begin
               cmd.hold_rst = 1'b1;
               cmd.pwr_drop = 1'b1;
               cmd.clk_drop = 1'b1;
               cmd.reclamp  = 1'b1;
            end
         end
         ST_CLKON: begin
            cmd.clk_up = 1'b1;
            tmr_clear  = 1'b1;
         end
         ST_UNCLAMP: begin
            cmd.unclamp = 1'b1;
            tmr_clear   = 1'b1;
         end
         ST_RELEASE: cmd.free_rst = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/pwrup_part_bank.sv
module pwrup_part_bank
   import pwrup_pkg::*;
#(
   parameter int NUM_PART = 8,
   parameter int IDX_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    idx,
   input  part_cmd_t           cmd,
   output logic [NUM_PART-1:0] rst_assert,
   output logic [NUM_PART-1:0] pwr_on_req,
   output logic [NUM_PART-1:0] clk_en,
   output logic [NUM_PART-1:0] clamp_rel
);

   generate
      for (genvar i = 0; i < NUM_PART; i++) begin : g_part
         logic sel;
         assign sel = (idx == IDX_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rst_assert[i] <= 1'b1;
               pwr_on_req[i] <= 1'b0;
               clk_en[i]     <= 1'b0;
               clamp_rel[i]  <= 1'b0;
            end else if (sel) begin
               if (cmd.hold_rst)      rst_assert[i] <= 1'b1;
               else if (cmd.free_rst) rst_assert[i] <= 1'b0;
               if (cmd.pwr_up)        pwr_on_req[i] <= 1'b1;
               else if (cmd.pwr_drop) pwr_on_req[i] <= 1'b0;
               if (cmd.clk_up)        clk_en[i]     <= 1'b1;
               else if (cmd.clk_drop) clk_en[i]     <= 1'b0;
               if (cmd.unclamp)       clamp_rel[i]  <= 1'b1;
               else if (cmd.reclamp)  clamp_rel[i]  <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
   import pwrup_pkg::*;
#(
   parameter int NUM_PART      = 8,
   parameter int TIMEOUT_TICKS = 25000,
   parameter int SETTLE_TICKS  = 10,
   parameter int SYNC_STAGES   = 0,
   localparam int IDX_W        = $clog2(NUM_PART),
   localparam int LIM_MAX      = (TIMEOUT_TICKS > SETTLE_TICKS) ? TIMEOUT_TICKS : SETTLE_TICKS,
   localparam int CNT_W        = $clog2(LIM_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                us_tick,
   input  logic                req,
   input  logic [IDX_W-1:0]    req_part,
   input  logic [NUM_PART-1:0] pwr_status,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [NUM_PART-1:0] rst_assert,
   output logic [NUM_PART-1:0] pwr_on_req,
   output logic [NUM_PART-1:0] clk_en,
   output logic [NUM_PART-1:0] clamp_rel
);

   generate
      if (NUM_PART < 2) begin : g_bad_num_part
         $error("pwrup_seq: NUM_PART must be at least 2");
      end
      if (TIMEOUT_TICKS < 1 || SETTLE_TICKS < 1) begin : g_bad_ticks
         $error("pwrup_seq: tick limits must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("pwrup_seq: SYNC_STAGES must be 0 to 3");
      end
   endgenerate

   logic [NUM_PART-1:0] status_s;
   logic [IDX_W-1:0]    idx_q;
   part_cmd_t           cmd;
   logic                tmr_clear;
   logic                tmr_hit;
   logic [CNT_W-1:0]    tmr_limit;
   logic                status_cur;

   pwrup_status_sync #(
      .WIDTH  (NUM_PART),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (pwr_status),
      .synced (status_s)
   );

   assign status_cur = status_s[idx_q];

   pwrup_tick_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tmr_clear),
      .tick  (us_tick),
      .limit (tmr_limit),
      .hit   (tmr_hit)
   );

   pwrup_fsm #(
      .NUM_PART      (NUM_PART),
      .IDX_W         (IDX_W),
      .CNT_W         (CNT_W),
      .TIMEOUT_TICKS (TIMEOUT_TICKS),
      .SETTLE_TICKS  (SETTLE_TICKS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .req_part   (req_part),
      .status_cur (status_cur),
      .tmr_hit    (tmr_hit),
      .idx_q      (idx_q),
      .cmd        (cmd),
      .tmr_clear  (tmr_clear),
      .tmr_limit  (tmr_limit),
      .busy       (busy),
      .done       (done),
      .err        (err)
   );

   pwrup_part_bank #(
      .NUM_PART (NUM_PART),
      .IDX_W    (IDX_W)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (idx_q),
      .cmd        (cmd),
      .rst_assert (rst_assert),
      .pwr_on_req (pwr_on_req),
      .clk_en     (clk_en),
      .clamp_rel  (clamp_rel)
   );

endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
   parameter int NUM_PART = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PART-1:0] pwr_status,
   input logic                busy,
   input logic                done,
   input logic                err,
   input logic [NUM_PART-1:0] rst_assert,
   input logic [NUM_PART-1:0] clk_en,
   input logic [NUM_PART-1:0] clamp_rel
);

   p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   p_err_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (!busy && $past(busy)));

   p_no_done_with_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   generate
      for (genvar i = 0; i < NUM_PART; i++) begin : g_part_chk
         p_clamp_needs_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
            clamp_rel[i] |-> clk_en[i]);

         p_clk_after_power_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(clk_en[i]) |-> $past(pwr_status[i]));

         p_release_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rst_assert[i]) |-> (clk_en[i] && clamp_rel[i]));
      end
   endgenerate

endmodule

bind pwrup_seq pwrup_seq_chk #(
   .NUM_PART (NUM_PART)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_status (pwr_status),
   .busy       (busy),
   .done       (done),
   .err        (err),
   .rst_assert (rst_assert),
   .clk_en     (clk_en),
   .clamp_rel  (clamp_rel)
);

// File: tb/sim_pwrup_seq.sv
`timescale 1ns/1ps
module sim_pwrup_seq;

   localparam int NP = 3;
   localparam int TO = 30;
   localparam int ST = 10;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          us_tick = 1'b0;
   logic          req = 1'b0;
   logic [IW-1:0] req_part = '0;
   logic [NP-1:0] pwr_status = '0;
   logic          busy, done, err;
   logic [NP-1:0] rst_assert, pwr_on_req, clk_en, clamp_rel;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   pwrup_seq #(
      .NUM_PART      (NP),
      .TIMEOUT_TICKS (TO),
      .SETTLE_TICKS  (ST),
      .SYNC_STAGES   (0)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .us_tick    (us_tick),
      .req        (req),
      .req_part   (req_part),
      .pwr_status (pwr_status),
      .busy       (busy),
      .done       (done),
      .err        (err),
      .rst_assert (rst_assert),
      .pwr_on_req (pwr_on_req),
      .clk_en     (clk_en),
      .clamp_rel  (clamp_rel)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Edge offset (from acceptance) of the n-th tick counted at or after edge 'after'
   function automatic int ntick(input int after, input int n, input int d);
      int k;
      k = (after + d - 1) / d;
      if (k < 1) k = 1;
      return (k + n - 1) * d;
   endfunction

   task automatic do_reset();
      rst_n   = 1'b0;
      req     = 1'b0;
      us_tick = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // s_rel = 0: partition already powered; otherwise status first seen at edge s_rel
   task automatic run_seq(input int p, input int d, input int s_rel,
                          input bit fresh, input bit mid, input bit edges);
      int eto, c, t1, t2;
      bit exp_to;
      int rclk, rclamp, rrel, rdone, rerr, ndone, last;
      logic [NP-1:0] mask, s_rst, s_pwr, s_clk, s_clamp;
      string tg;
      rclk = -1; rclamp = -1; rrel = -1; rdone = -1; rerr = -1; ndone = 0; last = -1;
      if (fresh) begin
         pwr_status = '0;
         do_reset();
      end
      pwr_status[p] = (s_rel == 0);
      eto    = ntick(2, TO, d);
      exp_to = (s_rel != 0) && (s_rel > eto);
      c      = (s_rel == 0) ? 2 : s_rel + 1;
      t1     = ntick(c + 1, ST, d);
      t2     = ntick(t1 + 2, ST, d);
      tg     = (s_rel != 0 && (s_rel == eto || s_rel == eto + 1)) ? "R6" : "R4";
      mask    = ~(NP'(1) << p);
      s_rst   = rst_assert & mask;
      s_pwr   = pwr_on_req & mask;
      s_clk   = clk_en & mask;
      s_clamp = clamp_rel & mask;
      req      = 1'b1;
      req_part = IW'(p);
      us_tick  = 1'b0;
      for (int rel = 0; rel < 3000; rel++) begin
         @(negedge clk);
         req = 1'b0;
         if (rel == 1) begin
            chk(rst_assert[p] == 1'b1, "R2 reset held", int'(rst_assert[p]), 1);
            chk(busy == 1'b1, "R2 busy", int'(busy), 1);
            chk(err == 1'b0, "R9 err cleared", int'(err), 0);
            if (edges)
               chk(pwr_on_req[p] == (s_rel != 0), (s_rel == 0) ? "R3 no power request" : "R4 power request",
                   int'(pwr_on_req[p]), int'(s_rel != 0));
         end
         if (clk_en[p] && rclk < 0) rclk = rel;
         if (clamp_rel[p] && rclamp < 0) rclamp = rel;
         if (rel >= 2 && !rst_assert[p] && rrel < 0) rrel = rel;
         if (done) begin
            ndone++;
            if (rdone < 0) rdone = rel;
         end
         if (err && rerr < 0) rerr = rel;
         if (rel >= 1 && !busy) begin
            last = rel;
            break;
         end
         us_tick = ((rel + 1) % d == 0);
         if (s_rel != 0 && rel + 1 == s_rel) pwr_status[p] = 1'b1;
         if (mid && rel == 3) begin
            req      = 1'b1;
            req_part = IW'((p + 1) % NP);
         end
      end
      us_tick = 1'b0;
      req     = 1'b0;
      if (last < 0) chk(1'b0, "R8 sequence ended", last, 0);
      if (exp_to) begin
         chk(rerr == eto, "R5 timeout cycle", rerr, eto);
         chk(err == 1'b1, "R5 err", int'(err), 1);
         chk(rst_assert[p] && !pwr_on_req[p] && !clk_en[p] && !clamp_rel[p], "R5 safe state",
             int'({rst_assert[p], pwr_on_req[p], clk_en[p], clamp_rel[p]}), 8);
         chk(ndone == 0, "R5 no done", ndone, 0);
      end else begin
         if (edges) begin
            chk(rclk == c, (s_rel == 0) ? "R3 clock edge" : tg, rclk, c);
            chk(rclamp == t1 + 1, "R7 clamp release", rclamp, t1 + 1);
         end
         chk(rrel == t2 + 1, "R8 reset release", rrel, t2 + 1);
         chk(rdone == t2 + 1, "R8 done cycle", rdone, t2 + 1);
         chk(ndone == 1, "R8 single done", ndone, 1);
         chk(err == 1'b0, "R6 no err on success", int'(err), 0);
      end
      chk(((rst_assert & mask) == s_rst) && ((pwr_on_req & mask) == s_pwr) &&
          ((clk_en & mask) == s_clk) && ((clamp_rel & mask) == s_clamp),
          mid ? "R10 mid request ignored" : "R11 others untouched",
          int'(clk_en & mask), int'(s_clk));
   endtask

   initial begin
      int eto2;
      do_reset();
      chk(!busy && !done && !err, "R1 flags", int'({busy, done, err}), 0);
      chk(rst_assert == '1, "R1 reset", int'(rst_assert), (1 << NP) - 1);
      chk(pwr_on_req == '0 && clk_en == '0 && clamp_rel == '0, "R1 controls",
          int'({pwr_on_req, clk_en, clamp_rel}), 0);

      for (int p = 0; p < NP; p++) begin
         for (int d = 1; d <= 3; d++) begin
            run_seq(p, d, 0, 1'b1, 1'b0, 1'b1);
            run_seq(p, d, 2 + p + d, 1'b1, 1'b0, 1'b1);
         end
      end

      // Timeout, then error persistence and clearing on the next request
      run_seq(1, 2, 9999, 1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         chk(err == 1'b1, "R9 err held", int'(err), 1);
      end
      run_seq(0, 1, 0, 1'b0, 1'b0, 1'b1);
      // Re-run of an awake partition: reset asserted again first
      run_seq(0, 1, 0, 1'b0, 1'b0, 1'b0);

      // Power status on the final timeout tick, and one edge later
      eto2 = ntick(2, TO, 2);
      run_seq(2, 2, eto2, 1'b1, 1'b0, 1'b1);
      run_seq(2, 2, eto2 + 1, 1'b1, 1'b0, 1'b1);

      // Request while busy
      run_seq(0, 1, 0, 1'b1, 1'b1, 1'b1);

      // Out-of-range index
      do_reset();
      req      = 1'b1;
      req_part = IW'(3);
      @(negedge clk);
      req = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(busy == 1'b0 && rst_assert == '1 && clk_en == '0 && pwr_on_req == '0,
             "R10 bad index ignored", int'({busy, clk_en}), 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule